// File: doc/BRIEF.md
# Step Attenuator Control Interface

This block is the digital control front end of a six-bit step attenuator with half-decibel resolution. It produces a six-bit attenuation word in which bit 5 weighs 16 dB and bit 0 weighs 0.5 dB, so 000000 is the reference-loss state and 111111 is 31.5 dB. The word can be programmed over a three-wire serial port (data, serial clock, latch enable) or from six parallel control inputs. A mode input picks the path. A serial cascade output lets several such blocks share one serial bus.

All control inputs are asynchronous to the block clock. They are brought in through synchronizers, and the serial clock is edge-detected in the block clock domain. One output register acts as a latch that both paths share. It passes its source while latch enable is high and holds while it is low. Reset stands in for power-up. A short time after reset is released, an initial word is loaded. In serial mode it comes from the parallel inputs. In parallel mode it comes from a two-bit preset input or from the parallel inputs, depending on latch enable.

Top module: `atten_ctl_if`

## Requirements
- R1: While rst_n is low, atten_word is 000000 and ser_out is 0. The serial shift register is also cleared.
- R2: With ser_mode high, every rising edge of ser_clk shifts ser_data into the shift register. This happens whatever the level of latch_en. After six edges, the first bit sent sits in bit 5 (16 dB) and the last bit sent sits in bit 0 (0.5 dB).
- R3: With ser_mode high and latch_en high, atten_word follows the shift register. With latch_en high at reset release, the word therefore becomes 000000 once the power-up load is done.
- R4: With ser_mode low and latch_en high, atten_word follows par_word (direct mode).
- R5: While latch_en is low, atten_word does not change, whatever happens on ser_clk, ser_data or par_word.
- R6: With ser_mode low, par_word can be captured by pulsing latch_en high and then low. The captured value is kept after par_word changes (latched mode).
- R7: At reset release with ser_mode high, atten_word is loaded from par_word. Any of the 64 values can be the initial state.
- R8: At reset release with ser_mode low and latch_en low, the word comes from preset_sel, where bit 0 is the first preset input and bit 1 is the second. The codes are 00 gives 000000, 10 gives 010000 (8 dB), 01 gives 100000 (16 dB) and 11 gives 111111 (31.5 dB). par_word has no effect.
- R9: At reset release with ser_mode low and latch_en high, preset_sel is ignored and atten_word equals par_word.
- R10: ser_out presents bit 5 of the shift register and changes only on a falling edge of ser_clk. When two blocks are chained and share ser_clk and latch_en, twelve shifted bits leave the first six in the downstream block and the last six in the upstream block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, stands in for power-up |
| ser_mode | input | 1 | 0 selects the parallel path, 1 selects the serial path |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| latch_en | input | 1 | High makes the output latch transparent, low holds it |
| par_word | input | 6 | Parallel control word, also the serial-mode power-up word |
| preset_sel | input | 2 | Power-up preset select for parallel mode with latch_en low |
| atten_word | output | 6 | Attenuation word, bit 5 = 16 dB, bit 0 = 0.5 dB |
| ser_out | output | 1 | Cascade output for the next block's ser_data |

## Verification
A corrupted shift register shows first on ser_out, at the falling serial clock edge after the bad stage reaches bit 5. It shows on atten_word only on the next latch_en high phase. A latch that does not hold shows on atten_word within three block clocks of a ser_clk or par_word change while latch_en is low. A wrong power-up choice is visible on atten_word a few clocks after reset release and stays there until latch_en goes high. For this reason every mode, latch_en level and preset code is swept through reset.

// File: rtl/atten_ctl_pkg.sv
package atten_ctl_pkg;

  localparam int PRESET_W = 2;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } boot_t;

endpackage

// File: rtl/atten_rst_sync.sv
module atten_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_ns = chain_q[STAGES-1];

endmodule

// File: rtl/atten_in_sync.sv
module atten_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_ns,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] st_q;
      logic [STAGES-1:0] st_d;

      always_comb begin
        st_d = {st_q[STAGES-2:0], din[b]};
      end

      always_ff @(posedge clk or negedge rst_ns) begin
        if (!rst_ns) st_q <= '0;
        else         st_q <= st_d;
      end

      assign dout[b] = st_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/atten_shift.sv
module atten_shift #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              mode_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic [WORD_W-1:0] sr_word,
  output logic              ser_out,
  output logic              rise,
  output logic              fall
);

  logic              sclk_q;
  logic [WORD_W-1:0] sr_q, sr_d;
  logic              so_q, so_d;
  logic              shift_en;

  assign rise     = sclk_s & ~sclk_q;
  assign fall     = ~sclk_s & sclk_q;
  assign shift_en = mode_s & rise;

  always_comb begin
    sr_d = sr_q;
    so_d = so_q;
    if (shift_en) sr_d = {sr_q[WORD_W-2:0], sdata_s};
    if (fall)     so_d = sr_q[WORD_W-1];
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      sclk_q <= 1'b0;
      sr_q   <= '0;
      so_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_s;
      sr_q   <= sr_d;
      so_q   <= so_d;
    end
  end

  assign sr_word = sr_q;
  assign ser_out = so_q;

endmodule

// File: rtl/atten_latch.sv
module atten_latch
  import atten_ctl_pkg::*;
#(
  parameter int WORD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_ns,
  input  logic                mode_s,
  input  logic                le_s,
  input  logic [PRESET_W-1:0] preset_s,
  input  logic [WORD_W-1:0]   par_s,
  input  logic [WORD_W-1:0]   sr_word,
  output logic [WORD_W-1:0]   atten_word,
  output logic                run
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_STAGES);

  boot_t             st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] word_q, word_d;
  logic [WORD_W-1:0] preset_word;
  logic [WORD_W-1:0] pup_word;

  always_comb begin
    case (preset_s)
      2'b01:   preset_word = {1'b1, {(WORD_W-1){1'b0}}};
      2'b10:   preset_word = {2'b01, {(WORD_W-2){1'b0}}};
      2'b11:   preset_word = '1;
      default: preset_word = '0;
    endcase
  end

  always_comb begin
    if (mode_s || le_s) pup_word = par_s;
    else                pup_word = preset_word;
  end

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    word_d = word_q;
    case (st_q)
      ST_WAIT: begin
        if (cnt_q == CNT_LAST) begin
          st_d   = ST_RUN;
          word_d = pup_word;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        if (le_s) word_d = mode_s ? sr_word : par_s;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q   <= ST_WAIT;
      cnt_q  <= '0;
      word_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      word_q <= word_d;
    end
  end

  assign atten_word = word_q;
  assign run        = (st_q == ST_RUN);

endmodule

// File: rtl/atten_ctl_if.sv
module atten_ctl_if
  import atten_ctl_pkg::*;
#(
  parameter int WORD_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_mode,
  input  logic                ser_data,
  input  logic                ser_clk,
  input  logic                latch_en,
  input  logic [WORD_W-1:0]   par_word,
  input  logic [PRESET_W-1:0] preset_sel,
  output logic [WORD_W-1:0]   atten_word,
  output logic                ser_out
);

  localparam int IN_W = WORD_W + PRESET_W + 4;

  logic                rst_ns;
  logic [IN_W-1:0]     in_raw, in_s;
  logic                mode_s, sdata_s, sclk_s, le_s;
  logic [PRESET_W-1:0] preset_s;
  logic [WORD_W-1:0]   par_s;
  logic [WORD_W-1:0]   sr_word;
  logic                rise, fall, run;

  assign in_raw = {ser_mode, ser_data, ser_clk, latch_en, preset_sel, par_word};
  assign {mode_s, sdata_s, sclk_s, le_s, preset_s, par_s} = in_s;

  atten_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_ns(rst_ns)
  );

  atten_in_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_ns(rst_ns), .din(in_raw), .dout(in_s)
  );

  atten_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_ns(rst_ns), .mode_s(mode_s), .sclk_s(sclk_s),
    .sdata_s(sdata_s), .sr_word(sr_word), .ser_out(ser_out),
    .rise(rise), .fall(fall)
  );

  atten_latch #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk(clk), .rst_ns(rst_ns), .mode_s(mode_s), .le_s(le_s),
    .preset_s(preset_s), .par_s(par_s), .sr_word(sr_word),
    .atten_word(atten_word), .run(run)
  );

endmodule

// File: rtl/atten_ctl_chk.sv
module atten_ctl_chk #(
  parameter int WORD_W = 6
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              run,
  input logic              le_s,
  input logic              mode_s,
  input logic              rise,
  input logic              fall,
  input logic              sdata_s,
  input logic [WORD_W-1:0] par_s,
  input logic [WORD_W-1:0] sr_word,
  input logic [WORD_W-1:0] atten_word,
  input logic              ser_out
);

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_ns |-> (atten_word == '0 && !ser_out && sr_word == '0));

  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_ns)
    (mode_s && rise) |=> sr_word == {$past(sr_word[WORD_W-2:0]), $past(sdata_s)});

  a_r3_serial_pass: assert property (@(posedge clk) disable iff (!rst_ns)
    (run && le_s && mode_s) |=> atten_word == $past(sr_word));

  a_r4_direct_follow: assert property (@(posedge clk) disable iff (!rst_ns)
    (run && le_s && !mode_s) |=> atten_word == $past(par_s));

  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (run && !le_s) |=> $stable(atten_word));

  a_r10_sout_on_fall: assert property (@(posedge clk) disable iff (!rst_ns)
    !fall |=> $stable(ser_out));

endmodule

bind atten_ctl_if atten_ctl_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .run(run), .le_s(le_s), .mode_s(mode_s),
  .rise(rise), .fall(fall), .sdata_s(sdata_s), .par_s(par_s),
  .sr_word(sr_word), .atten_word(atten_word), .ser_out(ser_out)
);

// File: tb/sim_atten_ctl_if.sv
`timescale 1ns/1ps
module sim_atten_ctl_if;

  logic       clk;
  logic       rst_n;
  logic       ser_mode, ser_data, ser_clk, latch_en;
  logic [5:0] par_word;
  logic [1:0] preset_sel;
  logic [5:0] atten_word, b_word;
  logic       ser_out, b_so;
  int         checks;
  int         errors;

  atten_ctl_if u0 (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ser_data(ser_data),
    .ser_clk(ser_clk), .latch_en(latch_en), .par_word(par_word),
    .preset_sel(preset_sel), .atten_word(atten_word), .ser_out(ser_out)
  );

  atten_ctl_if u1 (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .ser_data(ser_out),
    .ser_clk(ser_clk), .latch_en(latch_en), .par_word(par_word),
    .preset_sel(preset_sel), .atten_word(b_word), .ser_out(b_so)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic power_up(input logic m, input logic le, input logic [1:0] ps,
                          input logic [5:0] pw);
    rst_n = 1'b0;
    ser_mode = m; latch_en = le; preset_sel = ps; par_word = pw;
    ser_clk = 1'b0; ser_data = 1'b0;
    tick(4);
    check("R1 reset word", int'(atten_word), 0);
    check("R1 reset sout", int'(ser_out), 0);
    rst_n = 1'b1;
    tick(12);
  endtask

  task automatic send_bit(input logic b);
    ser_data = b;
    tick(4);
    ser_clk = 1'b1;
    tick(8);
    ser_clk = 1'b0;
    tick(8);
  endtask

  task automatic send_word(input logic [5:0] w);
    for (int i = 5; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic pulse_le;
    latch_en = 1'b1;
    tick(8);
    latch_en = 1'b0;
    tick(8);
  endtask

  function automatic logic [5:0] preset_exp(input logic [1:0] ps);
    case (ps)
      2'b01:   return 6'd32;
      2'b10:   return 6'd16;
      2'b11:   return 6'd63;
      default: return 6'd0;
    endcase
  endfunction

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    ser_mode = 1'b0; ser_data = 1'b0; ser_clk = 1'b0; latch_en = 1'b0;
    par_word = '0; preset_sel = '0;

    // R8: parallel, latch low, presets decide, par_word ignored
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) begin
        power_up(1'b0, 1'b0, 2'(p), 6'(k * 21));
        check("R8 preset word", int'(atten_word), int'(preset_exp(2'(p))));
      end
    end

    // R9: parallel, latch high, presets ignored
    for (int p = 0; p < 4; p++) begin
      for (int w = 0; w < 64; w += 3) begin
        power_up(1'b0, 1'b1, 2'(p), 6'(w));
        check("R9 par power-up", int'(atten_word), w);
      end
    end

    // R7: serial power-up from par_word, all 64 values
    for (int w = 0; w < 64; w++) begin
      power_up(1'b1, 1'b0, 2'(w & 3), 6'(w));
      check("R7 serial power-up", int'(atten_word), w);
    end

    // R3: serial power-up with latch high -> cleared shift register
    power_up(1'b1, 1'b1, 2'b11, 6'h2a);
    check("R3 serial transparent at power-up", int'(atten_word), 0);

    // R4: direct parallel mode sweep
    power_up(1'b0, 1'b1, 2'b00, 6'd0);
    for (int w = 0; w < 64; w++) begin
      par_word = 6'(w);
      tick(6);
      check("R4 direct follow", int'(atten_word), w);
    end

    // R6 / R5: latched parallel mode
    latch_en = 1'b0;
    tick(6);
    for (int w = 0; w < 64; w += 5) begin
      par_word = 6'(w);
      tick(4);
      pulse_le;
      par_word = ~6'(w);
      tick(8);
      check("R6 latched capture", int'(atten_word), w);
      check("R5 hold parallel", int'(atten_word), w);
    end

    // R2 / R3 / R5 / R10: serial loading of every word
    power_up(1'b1, 1'b0, 2'b00, 6'h15);
    send_word(6'h3f);
    check("R5 hold during shift", int'(atten_word), 6'h15);
    for (int w = 0; w < 64; w++) begin
      send_word(6'(w));
      check("R10 sout msb", int'(ser_out), int'(w >> 5));
      check("R5 hold before latch", int'(atten_word), (w == 0) ? 6'h15 : w - 1);
      latch_en = 1'b1;
      tick(8);
      check("R3 transparent pass", int'(atten_word), w);
      latch_en = 1'b0;
      tick(8);
      check("R2 shift order", int'(atten_word), w);
    end

    // R10: two-block cascade
    for (int k = 0; k < 6; k++) begin
      logic [5:0] wa, wb;
      wa = 6'(k * 11 + 3);
      wb = 6'(63 - k * 9);
      power_up(1'b1, 1'b0, 2'b00, 6'd0);
      send_word(wb);
      send_word(wa);
      pulse_le;
      check("R10 cascade upstream", int'(atten_word), int'(wa));
      check("R10 cascade downstream", int'(b_word), int'(wb));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule